// File: doc/BRIEF.md
# Byte-wide ADC readout controller

This block sits on the host side of a 16-bit successive-approximation converter whose result leaves through an 8-bit parallel bus. On a start request it drives the converter's active-low read/convert line low for a fixed number of clock cycles. It then follows the converter's active-low busy flag through a two-flop synchroniser.

When busy returns high, the first byte is on the bus and the controller latches it. It then flips the byte-select line and waits a settle delay. It latches the second byte and presents the joined word as a signed sample with a one-cycle valid strobe. The word is passed on unchanged, because the converter already codes it in two's complement.

Successive start pulses are kept a minimum number of cycles apart so the converter can reacquire its input. A request that arrives while the controller is busy is held until it can be served. Two timeouts recover the controller when the converter does not answer: one for busy failing to fall, and one for busy staying low too long.

Top module: `adc_byte_reader`

## Requirements
- R1: Each start pulse holds `adc_rc_n_o` low for exactly START_LOW_CYC clock cycles. Elaboration rejects a START_LOW_CYC outside the window [START_MIN_CYC, START_MAX_CYC].
- R2: No start pulse begins while the busy input is low.
- R3: Two falling edges of `adc_rc_n_o` are never closer than SPACING_CYC clock cycles.
- R4: A one-cycle request on `start_req_i` is remembered until a start pulse serves it, including a request made during a conversion. `ready_o` is 1 only when the controller is idle, the spacing interval has elapsed and no request is waiting.
- R5: With MSB_FIRST=1 (the default), `adc_byte_sel_o` is 0 while the controller waits for busy, so the upper byte is taken first. After that byte is captured, `adc_byte_sel_o` is driven to 1 to select the lower byte.
- R6: After a settle delay of SETTLE_CYC (at least 2) cycles, the second byte is captured. `sample_o` then equals {upper byte, lower byte} unchanged, `sample_valid_o` is high for one cycle, and `adc_byte_sel_o` is back at 0 in that same cycle.
- R7: If busy does not fall within FALL_TIMEOUT_CYC cycles after the start pulse ends, `error_o` pulses for one cycle, no sample is produced, and the controller returns to idle.
- R8: If busy stays low for more than LOW_LIMIT_CYC cycles, `error_o` pulses for one cycle, no sample is produced, and the controller returns to idle.
- R9: After reset, `adc_rc_n_o`=1, `adc_byte_sel_o`=0, `sample_valid_o`=0, `error_o`=0, `sample_o`=0 and `ready_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req_i | input | 1 | Request one conversion (a single-cycle pulse is enough) |
| ready_o | output | 1 | A request now would start a conversion at once |
| sample_o | output | SAMPLE_W | Last assembled signed sample |
| sample_valid_o | output | 1 | One-cycle strobe when `sample_o` updates |
| error_o | output | 1 | One-cycle strobe when a timeout aborts a conversion |
| adc_rc_n_o | output | 1 | Active-low read/convert line to the converter |
| adc_busy_n_i | input | 1 | Active-low busy flag from the converter (asynchronous) |
| adc_byte_sel_o | output | 1 | Byte-select line to the converter |
| adc_data_i | input | BUS_W | Converter output byte bus |

## Verification
The assertions assume that the busy flag is high whenever a start pulse could begin. In other words, the converter never starts a conversion by itself before the controller has seen busy return high. The assertions also assume that the bus holds the selected byte from the busy rising edge until byte-select changes. The bench's converter model keeps to this in two ways: it lowers busy only a few cycles after a start pulse, and it drives a filler pattern only while busy is low. When the bench holds busy low externally to test refusal of start pulses, no conversion is under way. The error cases use the same model, switched either to never lower busy or to never raise it.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PULSE,
      ST_WFALL,
      ST_WRISE,
      ST_SETTLE
   } rd_state_e;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o,
   output logic rise_o
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= RST_VAL;
      else        chain_q[0] <= async_i;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= RST_VAL;
      else        last_q <= chain_q[STAGES-1];
   end

   assign sync_o = chain_q[STAGES-1];
   assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic         zero_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load_i)          cnt_q <= load_val_i;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adc_byte_reader.sv
module adc_byte_reader
   import adc_rd_pkg::*;
#(
   parameter int BUS_W            = 8,
   parameter int SAMPLE_W         = 16,
   parameter int START_LOW_CYC    = 3,
   parameter int START_MIN_CYC    = 2,
   parameter int START_MAX_CYC    = 250,
   parameter int SPACING_CYC      = 250,
   parameter int SETTLE_CYC       = 2,
   parameter int FALL_TIMEOUT_CYC = 50,
   parameter int LOW_LIMIT_CYC    = 1000,
   parameter int SYNC_STAGES      = 2,
   parameter bit MSB_FIRST        = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_req_i,
   output logic                       ready_o,
   output logic signed [SAMPLE_W-1:0] sample_o,
   output logic                       sample_valid_o,
   output logic                       error_o,
   output logic                       adc_rc_n_o,
   input  logic                       adc_busy_n_i,
   output logic                       adc_byte_sel_o,
   input  logic [BUS_W-1:0]           adc_data_i
);
   localparam int   TMR_MAX   = max4(START_LOW_CYC, SETTLE_CYC, FALL_TIMEOUT_CYC, LOW_LIMIT_CYC);
   localparam int   TMR_W     = $clog2(TMR_MAX + 1);
   localparam int   SPC_W     = $clog2(SPACING_CYC + 1);
   localparam logic FIRST_SEL = MSB_FIRST ? 1'b0 : 1'b1;

   generate
      if (SAMPLE_W != 2 * BUS_W) begin : g_bad_width
         $error("SAMPLE_W must be twice BUS_W");
      end
      if (START_LOW_CYC < START_MIN_CYC || START_LOW_CYC > START_MAX_CYC) begin : g_bad_pulse
         $error("START_LOW_CYC outside the allowed pulse window");
      end
      if (SETTLE_CYC < 2) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (SPACING_CYC < 1 || FALL_TIMEOUT_CYC < 1 || LOW_LIMIT_CYC < 1) begin : g_bad_limits
         $error("spacing and timeout limits must be positive");
      end
   endgenerate

   rd_state_e          st_q, st_d;
   logic               busy_s, busy_rise;
   logic               ph_ld, ph_zero;
   logic [TMR_W-1:0]   ph_val;
   logic               gap_ok;
   logic               launch, cap_first, cap_second, err_d;
   logic               pending_q;
   logic               sel_q;
   logic [BUS_W-1:0]   first_q;
   logic [SAMPLE_W-1:0] joined;
   logic signed [SAMPLE_W-1:0] sample_q;
   logic               valid_q, err_q;

   adc_rd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_busy_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (adc_busy_n_i),
      .sync_o  (busy_s),
      .rise_o  (busy_rise)
   );

   adc_rd_timer #(.W(TMR_W)) u_phase_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (ph_ld),
      .load_val_i (ph_val),
      .zero_o     (ph_zero)
   );

   adc_rd_timer #(.W(SPC_W)) u_gap_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (launch),
      .load_val_i (SPC_W'(SPACING_CYC - 1)),
      .zero_o     (gap_ok)
   );

   always_comb begin
      st_d       = st_q;
      ph_ld      = 1'b0;
      ph_val     = '0;
      launch     = 1'b0;
      cap_first  = 1'b0;
      cap_second = 1'b0;
      err_d      = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (pending_q && gap_ok && busy_s) begin
               st_d   = ST_PULSE;
               ph_ld  = 1'b1;
               ph_val = TMR_W'(START_LOW_CYC - 1);
               launch = 1'b1;
            end
         end
         ST_PULSE: begin
            if (ph_zero) begin
               st_d   = ST_WFALL;
               ph_ld  = 1'b1;
               ph_val = TMR_W'(FALL_TIMEOUT_CYC - 1);
            end
         end
         ST_WFALL: begin
            if (!busy_s) begin
               st_d   = ST_WRISE;
               ph_ld  = 1'b1;
               ph_val = TMR_W'(LOW_LIMIT_CYC - 1);
            end else if (ph_zero) begin
               st_d  = ST_IDLE;
               err_d = 1'b1;
            end
         end
         ST_WRISE: begin
            if (busy_rise) begin
               st_d      = ST_SETTLE;
               cap_first = 1'b1;
               ph_ld     = 1'b1;
               ph_val    = TMR_W'(SETTLE_CYC - 1);
            end else if (ph_zero) begin
               st_d  = ST_IDLE;
               err_d = 1'b1;
            end
         end
         ST_SETTLE: begin
            if (ph_zero) begin
               st_d       = ST_IDLE;
               cap_second = 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   generate
      if (MSB_FIRST) begin : g_msb_first
         assign joined = {first_q, adc_data_i};
      end else begin : g_lsb_first
         assign joined = {adc_data_i, first_q};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         pending_q <= 1'b0;
         sel_q     <= FIRST_SEL;
         first_q   <= '0;
         sample_q  <= '0;
         valid_q   <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         st_q      <= st_d;
         pending_q <= launch ? start_req_i : (pending_q | start_req_i);
         valid_q   <= cap_second;
         err_q     <= err_d;
         if (cap_first) begin
            first_q <= adc_data_i;
            sel_q   <= ~FIRST_SEL;
         end else if (cap_second || err_d) begin
            sel_q   <= FIRST_SEL;
         end
         if (cap_second) sample_q <= $signed(joined);
      end
   end

   assign adc_rc_n_o     = (st_q != ST_PULSE);
   assign adc_byte_sel_o = sel_q;
   assign sample_o       = sample_q;
   assign sample_valid_o = valid_q;
   assign error_o        = err_q;
   assign ready_o        = (st_q == ST_IDLE) && gap_ok && !pending_q;
endmodule

// File: rtl/adc_byte_reader_chk.sv
module adc_byte_reader_chk #(
   parameter int   START_LOW_CYC = 3,
   parameter int   SPACING_CYC   = 250,
   parameter logic FIRST_SEL     = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic rc_n,
   input logic busy_n,
   input logic byte_sel,
   input logic valid,
   input logic err,
   input logic ready
);
   localparam int LW = $clog2(START_LOW_CYC + 2);
   localparam int GW = $clog2(SPACING_CYC + 1);

   logic [LW-1:0] low_cnt;
   logic [GW-1:0] since_fall;
   logic          rc_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt    <= '0;
         since_fall <= GW'(SPACING_CYC);
         rc_prev    <= 1'b1;
      end else begin
         rc_prev <= rc_n;
         if (rc_n)                                 low_cnt <= '0;
         else if (low_cnt != LW'(START_LOW_CYC + 1)) low_cnt <= low_cnt + 1'b1;
         if (rc_prev && !rc_n)                     since_fall <= GW'(1);
         else if (since_fall != GW'(SPACING_CYC))  since_fall <= since_fall + 1'b1;
      end
   end

   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rc_n) |-> low_cnt == LW'(START_LOW_CYC)); // R1
   AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rc_n) |-> busy_n); // R2
   AST_START_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rc_n) |-> since_fall == GW'(SPACING_CYC)); // R3
   AST_READY_LINES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (rc_n && byte_sel == FIRST_SEL)); // R4
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid); // R6
   AST_VALID_SEL_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> byte_sel == FIRST_SEL); // R6
   AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err); // R7
   AST_ERR_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(err && valid)); // R8
endmodule

bind adc_byte_reader adc_byte_reader_chk #(
   .START_LOW_CYC (START_LOW_CYC),
   .SPACING_CYC   (SPACING_CYC),
   .FIRST_SEL     (MSB_FIRST ? 1'b0 : 1'b1)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rc_n     (adc_rc_n_o),
   .busy_n   (adc_busy_n_i),
   .byte_sel (adc_byte_sel_o),
   .valid    (sample_valid_o),
   .err      (error_o),
   .ready    (ready_o)
);

// File: tb/adc_byte_reader_tb.sv
module adc_byte_reader_tb;
   localparam int START_LOW = 3;
   localparam int SPACING   = 60;
   localparam int SETTLE    = 2;
   localparam int FALL_TO   = 20;
   localparam int LOW_LIM   = 100;
   localparam int CONV      = 30;
   localparam int NVEC      = 8;
   localparam logic [15:0] VECS [NVEC] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
                                          16'h8000, 16'h1234, 16'hA5C3, 16'h00FF};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_req = 1'b0;
   logic ready, valid, err, rc_n, byte_sel;
   logic signed [15:0] sample;
   logic [7:0] adc_data;
   logic adc_busy_n;

   logic        model_busy = 1'b1;
   logic        force_low = 1'b0;
   logic        release_stuck = 1'b0;
   int          mode = 0;
   logic [15:0] cur_val = '0;
   logic [15:0] res_q = '0;

   int total = 0, fails = 0;
   int cyc = 0, low_run = 0, last_width = 0, fall_cnt = 0, last_fall = 0, min_gap = 1000000;
   int valid_cnt = 0, err_cnt = 0;
   logic        rc_prev = 1'b1;
   logic [15:0] got_sample = '0;

   always #10 clk = ~clk;

   assign adc_busy_n = model_busy & ~force_low;
   assign adc_data   = !model_busy ? 8'hEE : (byte_sel ? res_q[7:0] : res_q[15:8]);

   adc_byte_reader #(
      .START_LOW_CYC    (START_LOW),
      .SPACING_CYC      (SPACING),
      .SETTLE_CYC       (SETTLE),
      .FALL_TIMEOUT_CYC (FALL_TO),
      .LOW_LIMIT_CYC    (LOW_LIM)
   ) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_req_i    (start_req),
      .ready_o        (ready),
      .sample_o       (sample),
      .sample_valid_o (valid),
      .error_o        (err),
      .adc_rc_n_o     (rc_n),
      .adc_busy_n_i   (adc_busy_n),
      .adc_byte_sel_o (byte_sel),
      .adc_data_i     (adc_data)
   );

   // converter model
   initial begin
      forever begin
         @(negedge rc_n);
         if (mode != 1) begin
            repeat (2) @(posedge clk);
            #1 model_busy = 1'b0;
            if (mode == 2) wait (release_stuck);
            else repeat (CONV) @(posedge clk);
            #1 res_q = cur_val;
            model_busy = 1'b1;
         end
      end
   end

   // output monitor
   always @(negedge clk) begin
      cyc <= cyc + 1;
      rc_prev <= rc_n;
      if (!rc_n) low_run <= low_run + 1;
      else low_run <= 0;
      if (rc_n && !rc_prev) last_width <= low_run;
      if (!rc_n && rc_prev) begin
         if (fall_cnt > 0 && (cyc - last_fall) < min_gap) min_gap <= cyc - last_fall;
         fall_cnt  <= fall_cnt + 1;
         last_fall <= cyc;
      end
      if (valid) begin
         valid_cnt  <= valid_cnt + 1;
         got_sample <= sample;
      end
      if (err) err_cnt <= err_cnt + 1;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_req();
      @(negedge clk) start_req = 1'b1;
      @(negedge clk) start_req = 1'b0;
   endtask

   task automatic wait_valid(input int n0);
      for (int k = 0; k < 600 && valid_cnt <= n0; k++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      report();
      $finish;
   end

   initial begin
      int v0, e0, f0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(rc_n == 1'b1,     "R9 rc_n",     32'(rc_n),     1);
      chk(byte_sel == 1'b0, "R9 byte_sel", 32'(byte_sel), 0);
      chk(valid == 1'b0,    "R9 valid",    32'(valid),    0);
      chk(err == 1'b0,      "R9 error",    32'(err),      0);
      chk(sample == 16'sd0, "R9 sample",   32'(sample),   0);
      chk(ready == 1'b1,    "R9 ready",    32'(ready),    1);

      // vector walk: R1 R5 R6 and spacing R3
      for (int i = 0; i < NVEC; i++) begin
         cur_val = VECS[i];
         v0 = valid_cnt;
         pulse_req();
         wait_valid(v0);
         chk(valid_cnt == v0 + 1,      "R6 one strobe", 32'(valid_cnt - v0), 1);
         chk(got_sample == VECS[i],    "R5 R6 sample",  32'(got_sample),     32'(VECS[i]));
         chk(last_width == START_LOW,  "R1 pulse width", 32'(last_width),    START_LOW);
         chk(byte_sel == 1'b0,         "R6 sel restored", 32'(byte_sel),     0);
      end
      chk(min_gap >= SPACING, "R3 spacing", 32'(min_gap), SPACING);

      // R4: request during a conversion is held
      wait (ready);
      cur_val = 16'h5A5A;
      v0 = valid_cnt;
      f0 = fall_cnt;
      pulse_req();
      wait (!model_busy);
      pulse_req();
      chk(ready == 1'b0, "R4 ready low while held", 32'(ready), 0);
      wait_valid(v0);
      cur_val = 16'hC0DE;
      wait_valid(v0 + 1);
      chk(valid_cnt == v0 + 2, "R4 held request served", 32'(valid_cnt - v0), 2);
      chk(got_sample == 16'hC0DE, "R4 second sample", 32'(got_sample), 32'h0000C0DE);
      chk(fall_cnt == f0 + 2, "R4 pulse count", 32'(fall_cnt - f0), 2);
      chk(min_gap >= SPACING, "R3 spacing held request", 32'(min_gap), SPACING);

      // R2: busy low blocks start pulses
      wait (ready);
      force_low = 1'b1;
      wait_cycles(5);
      f0 = fall_cnt;
      v0 = valid_cnt;
      cur_val = 16'h0F0F;
      pulse_req();
      wait_cycles(80);
      chk(fall_cnt == f0, "R2 no pulse while busy", 32'(fall_cnt - f0), 0);
      chk(ready == 1'b0,  "R4 request pending", 32'(ready), 0);
      force_low = 1'b0;
      wait_valid(v0);
      chk(fall_cnt == f0 + 1, "R2 pulse after release", 32'(fall_cnt - f0), 1);
      chk(got_sample == 16'h0F0F, "R2 sample after release", 32'(got_sample), 32'h00000F0F);

      // R7: busy never falls
      wait (ready);
      mode = 1;
      e0 = err_cnt;
      v0 = valid_cnt;
      pulse_req();
      wait_cycles(START_LOW + FALL_TO + 10);
      chk(err_cnt == e0 + 1, "R7 error on missing busy", 32'(err_cnt - e0), 1);
      chk(valid_cnt == v0,   "R7 no sample",             32'(valid_cnt - v0), 0);
      wait_cycles(SPACING);
      chk(ready == 1'b1, "R7 back to idle", 32'(ready), 1);
      mode = 0;

      // R8: busy stuck low
      e0 = err_cnt;
      v0 = valid_cnt;
      mode = 2;
      cur_val = 16'h7777;
      pulse_req();
      wait_cycles(START_LOW + LOW_LIM + 20);
      chk(err_cnt == e0 + 1, "R8 error on long busy", 32'(err_cnt - e0), 1);
      chk(valid_cnt == v0,   "R8 no sample",          32'(valid_cnt - v0), 0);
      chk(byte_sel == 1'b0,  "R8 sel idle",           32'(byte_sel), 0);
      release_stuck = 1'b1;
      wait_cycles(20);
      chk(valid_cnt == v0, "R8 late busy rise ignored", 32'(valid_cnt - v0), 0);
      mode = 0;
      release_stuck = 1'b0;
      wait (ready);
      cur_val = 16'h8001;
      v0 = valid_cnt;
      pulse_req();
      wait_valid(v0);
      chk(got_sample == 16'h8001, "R8 recovery sample", 32'(got_sample), 32'h00008001);

      report();
      $finish;
   end
endmodule